// File: doc/BRIEF.md
# Segmented Address and Bus-Cycle Unit

This unit takes a memory request for one byte or one 16-bit word, picks the segment that goes with it, and forms a 20-bit physical address. It then runs the transfer over a 16-bit memory that is split into an even-byte bank and an odd-byte bank. The segment is chosen from the access class: instruction fetch, stack, general data, or string destination. A request can instead carry an override that names any of the four segments. A word at an odd address is split into two single-bank cycles. Every other access finishes in one bus cycle.

Requests arrive on a valid/ready handshake. The unit takes a request on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the edge after the completion pulse. While `req_ready` is low, `req_valid` and the request fields are ignored, so a requester that is held off must keep its request asserted until it is taken. The memory side is a plain strobe. Read data from memory is sampled on the clock edge that ends each strobe cycle. Segment values are sampled only on the accepting edge.

Top module: `seg_bus_unit`

## Requirements
- R1: The physical address is (segment value x 16) + offset. Any carry out of bit 19 is dropped, so the address wraps inside 1 MB.
- R2: Without an override, the access class selects the segment: class 0 (fetch) uses CS, class 1 (stack) uses SS, class 2 (data) uses DS, and class 3 (string destination) uses ES.
- R3: With `req_ovr_en` high, `req_ovr_seg` selects the segment instead of the class: 0 selects CS, 1 selects SS, 2 selects DS, and 3 selects ES.
- R4: The first fetch-class request after reset goes to address FFFF0h, whatever the segment, offset and override are. Later fetches follow R1 to R3.
- R5: A byte access runs one cycle at its address. The even bank is enabled when address bit 0 is 0, and the odd bank when it is 1. The byte is on data bits 7:0 for the even bank and on bits 15:8 for the odd bank.
- R6: A word at an even address runs one cycle with both banks enabled. The low byte is on bits 7:0 and the high byte on bits 15:8.
- R7: A word at an odd address A runs two cycles. The first enables only the odd bank at A and carries the low byte. The second enables only the even bank at A+1 (wrapping to 0 after FFFFFh) and carries the high byte.
- R8: Read results are little-endian: the byte at A goes to `rd_data[7:0]` and the byte at A+1 goes to `rd_data[15:8]`. For byte reads, `rd_data[15:8]` is zero.
- R9: `done` is high for exactly one clock, in the cycle after the last bus cycle of a request. `rd_data` is valid in that cycle.
- R10: `req_ready` is low while a request is in progress. Requests presented during that time are ignored and start no bus cycle.
- R11: After reset, `mem_strobe`, both bank enables and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_class | input | 2 | Access class (0 fetch, 1 stack, 2 data, 3 string destination) |
| req_ovr_en | input | 1 | Segment override present |
| req_ovr_seg | input | 2 | Override segment (0 CS, 1 SS, 2 DS, 3 ES) |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| seg_es | input | 16 | Extra segment value |
| req_offset | input | 16 | Offset within the segment |
| req_wdata | input | 16 | Write data (byte in bits 7:0 for byte writes) |
| mem_strobe | output | 1 | Bus cycle active |
| mem_we | output | 1 | Bus cycle is a write |
| mem_addr | output | 20 | Byte address of the cycle |
| mem_be_even | output | 1 | Even bank enable (data bits 7:0) |
| mem_be_odd | output | 1 | Odd bank enable (data bits 15:8) |
| mem_wdata | output | 16 | Write data lanes |
| mem_rdata | input | 16 | Read data lanes from memory |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Assembled read result, valid with done |

## Verification
The bench uses the default parameters: 16-bit segments and offsets, a shift of four, and a 20-bit address. At these sizes, the arithmetic model in the bench can produce the real top-of-memory corners, including the carry that wraps past FFFFFh and an odd word whose high byte wraps to address 0. The sweep covers every access class, with no override and with each of the four override codes. Each of these runs reads and writes, bytes and words, at even and odd offsets. Lane contents and bank enables are checked cycle by cycle against a byte-level memory model.

// File: rtl/seg_bus_pkg.sv
package seg_bus_pkg;
  typedef enum logic [1:0] {
    CLS_FETCH  = 2'd0,
    CLS_STACK  = 2'd1,
    CLS_DATA   = 2'd2,
    CLS_STRDST = 2'd3
  } acc_class_e;

  typedef enum logic [1:0] {
    SEL_CODE  = 2'd0,
    SEL_STACK = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_EXTRA = 2'd3
  } seg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CYC1,
    ST_CYC2,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/seg_select.sv
module seg_select
  import seg_bus_pkg::*;
#(
  parameter int SEG_W = 16
) (
  input  logic [1:0]       cls,
  input  logic             ovr_en,
  input  logic [1:0]       ovr_sel,
  input  logic [SEG_W-1:0] seg_cs,
  input  logic [SEG_W-1:0] seg_ss,
  input  logic [SEG_W-1:0] seg_ds,
  input  logic [SEG_W-1:0] seg_es,
  output logic [SEG_W-1:0] seg_out
);
  seg_sel_e dflt_sel;
  seg_sel_e pick;

  // class to default segment
  always_comb begin
    unique case (acc_class_e'(cls))
      CLS_FETCH:  dflt_sel = SEL_CODE;
      CLS_STACK:  dflt_sel = SEL_STACK;
      CLS_DATA:   dflt_sel = SEL_DATA;
      default:    dflt_sel = SEL_EXTRA;
    endcase
  end

  assign pick = ovr_en ? seg_sel_e'(ovr_sel) : dflt_sel;

  always_comb begin
    unique case (pick)
      SEL_CODE:  seg_out = seg_cs;
      SEL_STACK: seg_out = seg_ss;
      SEL_DATA:  seg_out = seg_ds;
      default:   seg_out = seg_es;
    endcase
  end
endmodule

// File: rtl/addr_gen.sv
module addr_gen #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int AW        = SEG_W + SEG_SHIFT,
  parameter logic [AW-1:0] BOOT_ADDR = '1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFS_W-1:0] offset,
  input  logic             boot_sel,
  output logic [AW-1:0]    phys
);
  localparam int OFS_PAD = AW - OFS_W;

  logic [AW-1:0] seg_base;
  logic [AW-1:0] ofs_ext;
  logic [AW-1:0] sum;

  assign seg_base = {seg, {SEG_SHIFT{1'b0}}};

  generate
    if (OFS_PAD > 0) begin : g_pad
      assign ofs_ext = {{OFS_PAD{1'b0}}, offset};
    end else begin : g_nopad
      assign ofs_ext = offset[AW-1:0];
    end
  endgenerate

  // AW-bit sum: the carry out falls off, so addresses wrap
  assign sum  = seg_base + ofs_ext;
  assign phys = boot_sel ? BOOT_ADDR : sum;
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import seg_bus_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_write,
  input  logic          acc_word,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic          mem_strobe,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_be_even,
  output logic          mem_be_odd,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  localparam int LANE = DW / 2;

  seq_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic          we_q;
  logic          word_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdat_q;
  logic          split;
  logic          wide;

  assign split = word_q & addr_q[0];
  assign wide  = word_q & ~addr_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      word_q  <= 1'b0;
      wdata_q <= '0;
      rdat_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (acc_valid) begin
          addr_q  <= acc_addr;
          we_q    <= acc_write;
          word_q  <= acc_word;
          wdata_q <= acc_wdata;
          state_q <= ST_CYC1;
        end
        ST_CYC1: begin
          if (wide)
            rdat_q <= mem_rdata;
          else if (addr_q[0])
            rdat_q <= {{LANE{1'b0}}, mem_rdata[DW-1:LANE]};
          else
            rdat_q <= {{LANE{1'b0}}, mem_rdata[LANE-1:0]};
          state_q <= split ? ST_CYC2 : ST_FIN;
        end
        ST_CYC2: begin
          rdat_q[DW-1:LANE] <= mem_rdata[LANE-1:0];
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_strobe  = (state_q == ST_CYC1) || (state_q == ST_CYC2);
    mem_we      = mem_strobe & we_q;
    mem_addr    = (state_q == ST_CYC2) ? addr_q + AW'(1) : addr_q;
    mem_be_even = 1'b0;
    mem_be_odd  = 1'b0;
    mem_wdata   = '0;
    if (state_q == ST_CYC1) begin
      mem_be_even = wide | ~addr_q[0];
      mem_be_odd  = wide | addr_q[0];
      if (wide)
        mem_wdata = wdata_q;
      else if (addr_q[0])
        mem_wdata = {wdata_q[LANE-1:0], {LANE{1'b0}}};
      else
        mem_wdata = {{LANE{1'b0}}, wdata_q[LANE-1:0]};
    end else if (state_q == ST_CYC2) begin
      mem_be_even = 1'b1;
      mem_wdata   = {{LANE{1'b0}}, wdata_q[DW-1:LANE]};
    end
  end

  assign acc_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FIN);
  assign rd_data   = rdat_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  split_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && word_q && mem_be_odd && !mem_be_even)
      |=> (mem_strobe && mem_be_even && !mem_be_odd && mem_addr == $past(mem_addr) + AW'(1)));

  // R5
  byte_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && !word_q) |-> ($onehot({mem_be_even, mem_be_odd}) && mem_be_odd == mem_addr[0]));

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_strobe |-> !acc_ready);

  // R6
  even_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_strobe && word_q && mem_be_even && mem_be_odd) |=> (done && !mem_strobe));
endmodule

// File: rtl/seg_bus_unit.sv
module seg_bus_unit
  import seg_bus_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int DW        = 16,
  parameter logic [SEG_W+SEG_SHIFT-1:0] BOOT_ADDR = 'hFFFF0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_word,
  input  logic [1:0]                 req_class,
  input  logic                       req_ovr_en,
  input  logic [1:0]                 req_ovr_seg,
  input  logic [SEG_W-1:0]           seg_cs,
  input  logic [SEG_W-1:0]           seg_ss,
  input  logic [SEG_W-1:0]           seg_ds,
  input  logic [SEG_W-1:0]           seg_es,
  input  logic [OFS_W-1:0]           req_offset,
  input  logic [DW-1:0]              req_wdata,
  output logic                       mem_strobe,
  output logic                       mem_we,
  output logic [SEG_W+SEG_SHIFT-1:0] mem_addr,
  output logic                       mem_be_even,
  output logic                       mem_be_odd,
  output logic [DW-1:0]              mem_wdata,
  input  logic [DW-1:0]              mem_rdata,
  output logic                       done,
  output logic [DW-1:0]              rd_data
);
  localparam int AW = SEG_W + SEG_SHIFT;

  logic [SEG_W-1:0] seg_pick;
  logic [AW-1:0]    phys;
  logic             boot_pend_q;
  logic             boot_sel;
  logic             take;

  assign boot_sel = boot_pend_q && (acc_class_e'(req_class) == CLS_FETCH);
  assign take     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      boot_pend_q <= 1'b1;
    else if (take && boot_sel)
      boot_pend_q <= 1'b0;
  end

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .cls     (req_class),
    .ovr_en  (req_ovr_en),
    .ovr_sel (req_ovr_seg),
    .seg_cs  (seg_cs),
    .seg_ss  (seg_ss),
    .seg_ds  (seg_ds),
    .seg_es  (seg_es),
    .seg_out (seg_pick)
  );

  addr_gen #(
    .SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .AW(AW), .BOOT_ADDR(BOOT_ADDR)
  ) u_agen (
    .seg      (seg_pick),
    .offset   (req_offset),
    .boot_sel (boot_sel),
    .phys     (phys)
  );

  bus_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (req_valid),
    .acc_ready   (req_ready),
    .acc_write   (req_write),
    .acc_word    (req_word),
    .acc_addr    (phys),
    .acc_wdata   (req_wdata),
    .mem_strobe  (mem_strobe),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be_even (mem_be_even),
    .mem_be_odd  (mem_be_odd),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .done        (done),
    .rd_data     (rd_data)
  );

  // R4
  boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && boot_sel) |=> !boot_pend_q);
endmodule

// File: tb/seg_bus_unit_bench.sv
`timescale 1ns/1ps
module seg_bus_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic [1:0]  req_class = 2'd0;
  logic        req_ovr_en = 1'b0;
  logic [1:0]  req_ovr_seg = 2'd0;
  logic [15:0] seg_cs = 16'h1234, seg_ss = 16'h2A5F, seg_ds = 16'h0C31, seg_es = 16'h7E02;
  logic [15:0] req_offset = '0;
  logic [15:0] req_wdata = '0;
  logic        mem_strobe, mem_we, mem_be_even, mem_be_odd, done;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, rd_data;
  logic [15:0] mem_rdata = '0;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;
  bit boot_pend = 1;
  logic [7:0] mb [bit [19:0]];

  always #10 clk = ~clk;

  seg_bus_unit u_seg_bus_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_class(req_class),
    .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg),
    .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds), .seg_es(seg_es),
    .req_offset(req_offset), .req_wdata(req_wdata),
    .mem_strobe(mem_strobe), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be_even(mem_be_even), .mem_be_odd(mem_be_odd), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdb(input logic [19:0] a);
    if (mb.exists(a)) return mb[a];
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction

  function automatic logic [15:0] segv(input logic [1:0] s);
    case (s)
      2'd0: return seg_cs;
      2'd1: return seg_ss;
      2'd2: return seg_ds;
      default: return seg_es;
    endcase
  endfunction

  task automatic issue(input bit wr, input bit wd, input logic [1:0] cls,
                       input bit oe, input logic [1:0] os, input logic [15:0] off,
                       input logic [15:0] wdat, input bit intrude);
    logic [19:0] p;
    logic [15:0] sg;
    logic [15:0] exp_rd;
    logic [19:0] ca [2];
    logic [1:0]  cb [2];
    logic [15:0] cw [2];
    int ns;
    bit seen_done;
    int exp_ns;
    sg = oe ? segv(os) : segv(cls);
    if (boot_pend && cls == 2'd0) begin
      p = 20'hFFFF0;
      boot_pend = 0;
    end else begin
      p = {sg, 4'h0} + {4'h0, off};
    end
    exp_rd = wd ? {rdb(p + 20'd1), rdb(p)} : {8'h00, rdb(p)};
    exp_ns = (wd && p[0]) ? 2 : 1;
    ns = 0;
    seen_done = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_class = cls;
    req_ovr_en = oe; req_ovr_seg = os; req_offset = off; req_wdata = wdat;
    for (int k = 0; k < 8 && !seen_done; k++) begin
      @(negedge clk);
      if (intrude && !done) begin
        chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        req_valid = 1'b1;
        req_offset = off ^ 16'h0100;
        req_write = ~wr;
      end else begin
        req_valid = 1'b0;
      end
      if (mem_strobe) begin
        if (ns < 2) begin
          ca[ns] = mem_addr; cb[ns] = {mem_be_odd, mem_be_even}; cw[ns] = mem_wdata;
        end
        ns++;
        if (mem_we) begin
          if (mem_be_even) mb[{mem_addr[19:1], 1'b0}] = mem_wdata[7:0];
          if (mem_be_odd)  mb[{mem_addr[19:1], 1'b1}] = mem_wdata[15:8];
        end else begin
          mem_rdata = {rdb({mem_addr[19:1], 1'b1}), rdb({mem_addr[19:1], 1'b0})};
        end
      end
      if (done) begin
        seen_done = 1;
        req_valid = 1'b0;
        if (!wr) chk(rd_data == exp_rd, "R8", "read data", rd_data, exp_rd);
      end
    end
    chk(seen_done, "R9", "done seen", seen_done, 1);
    chk(ns == exp_ns, wd ? "R7" : "R5", "bus cycle count", ns, exp_ns);
    if (ns >= 1) begin
      // R1 R2 R3 address of first cycle
      chk(ca[0] == p, oe ? "R3" : "R2", "first address", ca[0], p);
      if (!wd) begin
        chk(cb[0] == (p[0] ? 2'b10 : 2'b01), "R5", "byte bank", cb[0], p[0] ? 2'b10 : 2'b01);
        if (wr) begin
          if (p[0]) chk(cw[0][15:8] == wdat[7:0], "R5", "odd lane", cw[0], wdat[7:0]);
          else      chk(cw[0][7:0]  == wdat[7:0], "R5", "even lane", cw[0], wdat[7:0]);
        end
      end else if (!p[0]) begin
        chk(cb[0] == 2'b11, "R6", "word banks", cb[0], 2'b11);
        if (wr) chk(cw[0] == wdat, "R6", "word lanes", cw[0], wdat);
      end else begin
        chk(cb[0] == 2'b10, "R7", "split first bank", cb[0], 2'b10);
        if (wr) chk(cw[0][15:8] == wdat[7:0], "R7", "split low byte", cw[0], wdat[7:0]);
      end
    end
    if (ns >= 2 && exp_ns == 2) begin
      chk(ca[1] == p + 20'd1, "R7", "split second address", ca[1], p + 20'd1);
      chk(cb[1] == 2'b01, "R7", "split second bank", cb[1], 2'b01);
      if (wr) chk(cw[1][7:0] == wdat[15:8], "R7", "split high byte", cw[1], wdat[15:8]);
    end
    @(negedge clk);
    chk(!done && !mem_strobe, "R9", "done single and no extra cycle", {done, mem_strobe}, 0);
    chk(req_ready, "R10", "ready after completion", req_ready, 1);
    if (intrude) begin
      @(negedge clk);
      chk(!mem_strobe, "R10", "ignored request started nothing", mem_strobe, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!mem_strobe && !mem_be_even && !mem_be_odd, "R11", "no bus after reset",
        {mem_strobe, mem_be_even, mem_be_odd}, 0);
    chk(req_ready && !done, "R11", "ready and idle", {req_ready, done}, 2'b10);
    // R4 first fetch goes to the boot address, then CS-relative
    issue(0, 1, 2'd0, 0, 2'd0, 16'h0040, 16'h0, 0);
    issue(0, 1, 2'd0, 0, 2'd0, 16'h0040, 16'h0, 0);
    n = 0;
    for (int c = 0; c < 4; c++)
      for (int o = 0; o < 5; o++)
        for (int wr = 0; wr < 2; wr++)
          for (int wd = 0; wd < 2; wd++)
            for (int par = 0; par < 2; par++) begin
              logic [15:0] off;
              off = 16'h3C40 + 16'(n * 37);
              off[0] = par[0];
              issue(wr[0], wd[0], c[1:0], o != 0, 2'((o + 3) % 4), off,
                    16'hA000 + 16'(n * 13), 0);
              n++;
            end
    // R1 wrap of the sum past 1 MB
    seg_ds = 16'hFFFF;
    issue(0, 0, 2'd2, 0, 2'd0, 16'h0010, 16'h0, 0);
    // R7 odd word at the last byte wraps its high byte to address 0
    seg_ds = 16'hF000;
    issue(1, 1, 2'd2, 0, 2'd0, 16'hFFFF, 16'hBEEF, 0);
    issue(0, 1, 2'd2, 0, 2'd0, 16'hFFFF, 16'h0, 0);
    // R10 requests during a busy split word are ignored
    issue(0, 1, 2'd1, 0, 2'd0, 16'h0123, 16'h0, 1);
    issue(1, 0, 2'd3, 1, 2'd0, 16'h0457, 16'h0077, 1);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule